// File: doc/BRIEF.md
# Color Measurement Cycle Sequencer

This block runs the measurement cycles of a four-channel (red, green, blue, white) light sensor. A 16-bit configuration word chooses how long each integration window lasts and whether windows run continuously or one at a time on request. It can also hold the sensor off. Window length is counted in pulses of a one-millisecond tick input. When a window closes, the block copies four externally accumulated 16-bit channel counts into holding registers and raises a one-cycle valid pulse. Those held values stay readable until the next window closes, and shutdown does not disturb them.

The configuration word reads back through `cfg_rdata`. Reserved bits read as zero. The one-shot trigger bit reads as 1 while its forced cycle is pending or running and clears itself when that cycle completes. `integ_on` is high while a window is open, so the front end knows when to accumulate.

Top module: `color_meas_seq`

## Requirements
- R1: After reset, `cfg_rdata` is 0x0000, every channel result is 0 and `res_valid` is 0.
- R2: The configuration word is read back as {8'h00, 1'b0, itime[2:0], 1'b0, trig, force, sd}, where itime is bits 6:4, trig is bit 2, force is bit 1 and sd is bit 0 of the written word. All other written bits are dropped and read as 0.
- R3: itime code k (0 to 5) gives a window of 40·2^k tick pulses. Results and `res_valid` appear on the clock edge after the cycle that carries the final tick of the window.
- R4: itime codes 6 and 7 give the longest window, 1280 ticks.
- R5: With force = 0 and sd = 0, windows repeat with no gap, so consecutive `res_valid` pulses are exactly one window length apart when the tick is held high.
- R6: With force = 1, a write with trig = 1 starts exactly one window, and a write with trig = 0 starts none. A trig bit written while force = 0 or sd = 1 is dropped.
- R7: The trig bit reads 1 from its write until the forced window finishes. It reads 0 from the cycle in which that window's `res_valid` is high.
- R8: Writing sd = 1 closes the open window at once. No `res_valid` follows, and the held results are unchanged. Writing sd = 0 again starts a fresh window of full length.
- R9: All four results load together in one cycle with a single-cycle `res_valid`. Each result is the `acc_in` slice sampled in the window's final cycle: red in bits 15:0, green in 31:16, blue in 47:32, white in 63:48.
- R10: A configuration write during an open window leaves that window's length unchanged. The new itime applies from the next window.
- R11: The window advances only on cycles with `ms_tick` high. Without ticks, a window stays open indefinitely and produces no results.
- R12: The held results change only when a window completes, and they stay readable during shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_rdata | output | 16 | Configuration read-back |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| acc_in | input | 64 | Four channel accumulator values, red lowest |
| res_out | output | 64 | Four held channel results, red lowest |
| res_valid | output | 1 | One-cycle pulse when results load |
| integ_on | output | 1 | High while an integration window is open |

## Verification
The assertions rely on every window being at least 40 ticks long and on `ms_tick` being a plain level that the sequencer samples. They also rely on configuration writes arriving as single-cycle strobes. The bench drives each write for exactly one cycle at a falling edge. It holds `acc_in` steady across a window and changes it only after a result has been seen. It puts the block into shutdown before each scenario, so no window left open by an earlier scenario can finish inside the next one.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

  localparam int unsigned ITIME_W = 3;

  typedef struct packed {
    logic [ITIME_W-1:0] itime;
    logic               trig;
    logic               force_md;
    logic               sd;
  } cfg_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_INTEG = 1'b1} seq_state_t;

  // Window length in ticks: base doubled per code step, saturating at max_sh.
  function automatic int unsigned win_ticks(input logic [ITIME_W-1:0] code,
                                            input int unsigned base,
                                            input int unsigned max_sh);
    int unsigned sh;
    sh = {29'd0, code};
    if (sh > max_sh) sh = max_sh;
    return base << sh;
  endfunction

endpackage

// File: rtl/colseq_cfg_reg.sv
module colseq_cfg_reg
  import colseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        fin_forced,
  output cfg_t        cfg_o,
  output logic [15:0] rd_data
);

  cfg_t cfg_q, cfg_d;
  logic unused_rsvd;

  assign unused_rsvd = ^{wr_data[15:7], wr_data[3]};

  always_comb begin
    cfg_d = cfg_q;
    if (fin_forced) cfg_d.trig = 1'b0;
    if (wr_en) begin
      cfg_d.itime    = wr_data[6:4];
      cfg_d.force_md = wr_data[1];
      cfg_d.sd       = wr_data[0];
      if (!wr_data[1] || wr_data[0]) cfg_d.trig = 1'b0;
      else if (wr_data[2])           cfg_d.trig = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o   = cfg_q;
  assign rd_data = {8'h00, 1'b0, cfg_q.itime, 1'b0, cfg_q.trig, cfg_q.force_md, cfg_q.sd};

endmodule

// File: rtl/colseq_win_timer.sv
module colseq_win_timer
  import colseq_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 40,
  parameter int unsigned MAX_SHIFT  = 5,
  localparam int unsigned CNT_W     = $clog2(BASE_TICKS << MAX_SHIFT)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  input  logic [ITIME_W-1:0] code,
  output logic               last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  int unsigned      lim;

  always_comb begin
    lim   = win_ticks(code, BASE_TICKS, MAX_SHIFT);
    last  = (cnt_q == CNT_W'(lim - 1));
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/colseq_ctrl.sv
module colseq_ctrl
  import colseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  cfg_t               cfg_i,
  input  logic               ms_tick,
  input  logic               win_last,
  output logic               integ_on,
  output logic               cnt_clr,
  output logic               cnt_en,
  output logic [ITIME_W-1:0] win_code,
  output logic               fin,
  output logic               fin_forced
);

  seq_state_t         st_q, st_d;
  logic [ITIME_W-1:0] code_q, code_d;
  logic               forced_q, forced_d;
  logic               running, go, start;

  always_comb begin
    running    = (st_q == ST_INTEG);
    fin        = running && !cfg_i.sd && win_last && ms_tick;
    fin_forced = fin && forced_q;
    go         = !cfg_i.sd && (!cfg_i.force_md || (cfg_i.trig && !fin_forced));
    start      = go && (!running || fin);
    st_d       = st_q;
    code_d     = code_q;
    forced_d   = forced_q;
    if (running && cfg_i.sd) begin
      st_d = ST_IDLE;
    end else if (start) begin
      st_d     = ST_INTEG;
      code_d   = cfg_i.itime;
      forced_d = cfg_i.force_md;
    end else if (fin) begin
      st_d = ST_IDLE;
    end
    cnt_clr = start;
    cnt_en  = running && ms_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      code_q   <= '0;
      forced_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      code_q   <= code_d;
      forced_q <= forced_d;
    end
  end

  assign integ_on = running;
  assign win_code = code_q;

endmodule

// File: rtl/colseq_result_bank.sv
module colseq_result_bank #(
  parameter int unsigned CH = 4,
  parameter int unsigned DW = 16,
  localparam int unsigned BUS_W = CH * DW
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUS_W-1:0] acc_in,
  output logic [BUS_W-1:0] res_out,
  output logic             valid
);

  logic valid_q;

  for (genvar gi = 0; gi < CH; gi++) begin : g_ch
    logic [DW-1:0] hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold_q <= '0;
      else if (load) hold_q <= acc_in[gi*DW +: DW];
    end
    assign res_out[gi*DW +: DW] = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= load;
  end

  assign valid = valid_q;

  // R9: windows span many ticks, so the load pulse never repeats next cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

endmodule

// File: rtl/color_meas_seq.sv
module color_meas_seq
  import colseq_pkg::*;
#(
  parameter int unsigned CH         = 4,
  parameter int unsigned DW         = 16,
  parameter int unsigned BASE_TICKS = 40,
  parameter int unsigned MAX_SHIFT  = 5,
  localparam int unsigned BUS_W     = CH * DW
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  input  logic             ms_tick,
  input  logic [BUS_W-1:0] acc_in,
  output logic [BUS_W-1:0] res_out,
  output logic             res_valid,
  output logic             integ_on
);

  cfg_t               cfg;
  logic               fin, fin_forced, cnt_clr, cnt_en, win_last;
  logic [ITIME_W-1:0] win_code;

  colseq_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr),
    .wr_data    (cfg_wdata),
    .fin_forced (fin_forced),
    .cfg_o      (cfg),
    .rd_data    (cfg_rdata)
  );

  colseq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_i      (cfg),
    .ms_tick    (ms_tick),
    .win_last   (win_last),
    .integ_on   (integ_on),
    .cnt_clr    (cnt_clr),
    .cnt_en     (cnt_en),
    .win_code   (win_code),
    .fin        (fin),
    .fin_forced (fin_forced)
  );

  colseq_win_timer #(
    .BASE_TICKS (BASE_TICKS),
    .MAX_SHIFT  (MAX_SHIFT)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .code  (win_code),
    .last  (win_last)
  );

  colseq_result_bank #(
    .CH (CH),
    .DW (DW)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (fin),
    .acc_in  (acc_in),
    .res_out (res_out),
    .valid   (res_valid)
  );

  // R12: held results move only together with the valid pulse
  a_r12_hold_until_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (res_out != $past(res_out)) |-> res_valid);

  // R8: a cycle spent in shutdown is never followed by a result
  a_r8_no_result_in_sd: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.sd |=> !res_valid);

  // R11: a result always follows a tick cycle
  a_r11_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(ms_tick));

  // R7: trigger read-back drops only on completion or on a write
  a_r7_trig_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_rdata[2]) |-> (res_valid || $past(cfg_wr)));

endmodule

// File: tb/tb_color_meas_seq.sv
`timescale 1ns/1ps
module tb_color_meas_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        ms_tick;
  logic [63:0] acc_in;
  logic [63:0] res_out;
  logic        res_valid;
  logic        integ_on;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int vcnt  = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  color_meas_seq dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .ms_tick   (ms_tick),
    .acc_in    (acc_in),
    .res_out   (res_out),
    .res_valid (res_valid),
    .integ_on  (integ_on)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (res_valid) vcnt <= vcnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [15:0] d);
    @(negedge clk);
    cfg_wr    = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr    = 1'b0;
    cfg_wdata = 16'h0;
  endtask

  task automatic wait_valid(input int lim, output int at);
    int k;
    k = 0;
    @(negedge clk);
    while (!res_valid && k < lim) begin
      @(negedge clk);
      k++;
    end
    at = res_valid ? cyc : -1;
  endtask

  task automatic quiesce();
    wr_cfg(16'h0001);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [63:0] pat(input int s);
    return {16'hD000 + 16'(s), 16'hB000 + 16'(s), 16'h6000 + 16'(s), 16'h1000 + 16'(s)};
  endfunction

  task automatic t_reset();
    chk(cfg_rdata == 16'h0, "R1 cfg_rdata", 64'(cfg_rdata), 64'h0);
    chk(res_out == 64'h0, "R1 res_out", res_out, 64'h0);
    chk(res_valid == 1'b0, "R1 res_valid", 64'(res_valid), 64'h0);
  endtask

  task automatic t_readback();
    quiesce();
    wr_cfg(16'hABDF);
    chk(cfg_rdata == 16'h0053, "R2 reserved bits dropped", 64'(cfg_rdata), 64'h53);
    wr_cfg(16'h0004);
    chk(cfg_rdata == 16'h0000, "R6 trig dropped in auto mode", 64'(cfg_rdata), 64'h0);
    quiesce();
  endtask

  task automatic t_window(input int code, input int n);
    int c0, at, v0;
    quiesce();
    acc_in = pat(code);
    wr_cfg(16'((code << 4) | 6));
    c0 = cyc;
    chk(cfg_rdata[2] == 1'b1, "R7 trig reads 1 while pending", 64'(cfg_rdata[2]), 64'h1);
    wait_valid(3000, at);
    chk(at == c0 + n + 1, (code > 5) ? "R4 saturated window length" : "R3 window length",
        64'(at - c0), 64'(n + 1));
    chk(res_out == pat(code), "R9 all channels loaded", res_out, pat(code));
    chk(cfg_rdata[2] == 1'b0, "R7 trig cleared on completion", 64'(cfg_rdata[2]), 64'h0);
    @(negedge clk);
    chk(res_valid == 1'b0, "R9 valid lasts one cycle", 64'(res_valid), 64'h0);
    if (code == 0) begin
      v0 = vcnt;
      repeat (150) @(negedge clk);
      chk(vcnt == v0, "R6 one forced window only", 64'(vcnt - v0), 64'h0);
      chk(integ_on == 1'b0, "R6 idle after forced window", 64'(integ_on), 64'h0);
    end
  endtask

  task automatic t_force_no_trig();
    int v0;
    quiesce();
    wr_cfg(16'h0002);
    v0 = vcnt;
    repeat (200) @(negedge clk);
    chk(vcnt == v0, "R6 trig=0 starts nothing", 64'(vcnt - v0), 64'h0);
    chk(integ_on == 1'b0, "R6 no window open", 64'(integ_on), 64'h0);
  endtask

  task automatic t_auto();
    int c0, a1, a2;
    quiesce();
    acc_in = pat(40);
    wr_cfg(16'h0000);
    c0 = cyc;
    wait_valid(3000, a1);
    chk(a1 == c0 + 41, "R5 first auto window", 64'(a1 - c0), 64'd41);
    chk(res_out == pat(40), "R9 first auto result", res_out, pat(40));
    acc_in = pat(41);
    wait_valid(3000, a2);
    chk(a2 == a1 + 40, "R5 back-to-back interval", 64'(a2 - a1), 64'd40);
    chk(res_out == pat(41), "R9 second auto result", res_out, pat(41));
    quiesce();
  endtask

  task automatic t_midwrite();
    int c0, a1, a2;
    quiesce();
    wr_cfg(16'h0000);
    c0 = cyc;
    repeat (9) @(negedge clk);
    wr_cfg(16'h0010);
    wait_valid(3000, a1);
    chk(a1 == c0 + 41, "R10 open window keeps length", 64'(a1 - c0), 64'd41);
    wait_valid(3000, a2);
    chk(a2 == a1 + 80, "R10 next window uses new code", 64'(a2 - a1), 64'd80);
    quiesce();
  endtask

  task automatic t_shutdown();
    int at, v0, c0;
    quiesce();
    acc_in = pat(50);
    wr_cfg(16'h0006);
    wait_valid(3000, at);
    chk(res_out == pat(50), "R12 baseline result", res_out, pat(50));
    acc_in = pat(51);
    wr_cfg(16'h0006);
    repeat (20) @(negedge clk);
    wr_cfg(16'h0001);
    v0 = vcnt;
    repeat (100) @(negedge clk);
    chk(vcnt == v0, "R8 no result after abort", 64'(vcnt - v0), 64'h0);
    chk(res_out == pat(50), "R12 results kept in shutdown", res_out, pat(50));
    chk(integ_on == 1'b0, "R8 window closed", 64'(integ_on), 64'h0);
    wr_cfg(16'h0006);
    c0 = cyc;
    wait_valid(3000, at);
    chk(at == c0 + 41, "R8 fresh full window", 64'(at - c0), 64'd41);
    chk(res_out == pat(51), "R8 new result after resume", res_out, pat(51));
  endtask

  task automatic t_no_tick();
    int v0, c0, at;
    quiesce();
    ms_tick = 1'b0;
    acc_in  = pat(60);
    wr_cfg(16'h0006);
    v0 = vcnt;
    repeat (300) @(negedge clk);
    chk(vcnt == v0, "R11 no progress without ticks", 64'(vcnt - v0), 64'h0);
    chk(integ_on == 1'b1, "R11 window stays open", 64'(integ_on), 64'h1);
    ms_tick = 1'b1;
    c0 = cyc;
    wait_valid(3000, at);
    chk(at == c0 + 40, "R11 completes after 40 ticks", 64'(at - c0), 64'd40);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    cfg_wr    = 1'b0;
    cfg_wdata = 16'h0;
    ms_tick   = 1'b0;
    acc_in    = 64'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    ms_tick = 1'b1;
    t_readback();
    for (int c = 0; c < 8; c++) t_window(c, (c > 5) ? 1280 : (40 << c));
    t_force_no_trig();
    t_auto();
    t_midwrite();
    t_shutdown();
    t_no_tick();
    finish_run();
  end

endmodule